// File: doc/BRIEF.md
# Transceiver FIFO Status Logic

This block sits between a serial transceiver core and an 8-bit processor bus. It holds a receive queue and a transmit queue, each storing 11-bit words made of three upper bits and one data byte. It also keeps the receiver and transmitter status flags. The processor pops received words through an 8-bit data port and finds the upper bits of the head word in the low bits of a status byte. A processor write to the data port queues a byte, together with three upper bits supplied by a control register, for the serializer.

The status flags follow the receiver's events. A start sequence marks the receiver busy, end-of-message or a fault ends that, and a fault latches an error flag that stays set until software reads the error register or the transceiver is reset. A data-ready flag tracks whether the head of the receive queue holds fresh data. A two-bit select picks which of these conditions drives the receiver interrupt request. All state is registered on `clk`. Flags, the status byte, the data port and the interrupt are read combinationally from that state.

Top module: `xcvr_fifo_status`

## Requirements
- R1: After synchronous reset, `status` is 8'h00, `rx_irq` is 0 with select 00, `tx_word_valid` is 0 and `rd_data` is 8'h00.
- R2: The `status` bit layout is: bit 7 transmit queue full, bit 6 transmitter busy, bit 5 receive error, bit 4 receiver active, bit 3 data ready, bits 2:0 the upper bits of the receive head word.
- R3: A pulse on `wr_data` queues the word {`tx_hi`, `wr_byte`}. The transmit queue holds 4 words and presents them in order on `tx_word` while `tx_word_valid` is high, and `tx_pop` removes one. Status bit 7 is high exactly while 4 words are held, and a write while full is dropped.
- R4: Receive error (status bit 5) sets on `rx_fault` or on a receive overflow. It clears on `rd_err` or `xrst`. A set and a clear in the same cycle leave it set.
- R5: Receiver active (status bit 4) sets on `rx_start` and clears on `rx_eom` or on any error event. A clear in the same cycle as a set wins.
- R6: Data ready (status bit 3) sets when a word enters the receive queue. It stays set while pops leave words behind and clears when the last word is popped. An error event also clears it, and it then stays low, even with words still queued, until the next word arrives.
- R7: The receive queue holds 4 words. A word that arrives while the queue is full and not being popped is dropped and counts as an error event.
- R8: `rd_data` and status bits 2:0 show the receive head word, and a pulse on `rd_data_en` pops it. A pop on an empty queue leaves the queue unchanged and the port keeps showing the last word popped.
- R9: `rx_irq` by `irq_sel`: 00 gives receive-queue-full OR error, 01 gives data-ready OR error, 10 gives 0, 11 gives receiver active.
- R10: Status bit 6 equals `tx_busy` whatever `loopback` is, while `tx_active` is `tx_busy` AND NOT `loopback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xrst | input | 1 | Transceiver reset, clears the error flag |
| rx_push | input | 1 | Deserializer delivers a word |
| rx_word | input | 11 | Received word, upper bits 10:8 |
| rx_start | input | 1 | Valid start sequence seen |
| rx_eom | input | 1 | End of message seen |
| rx_fault | input | 1 | Receiver reports an error |
| rd_data_en | input | 1 | Processor reads (pops) the data port |
| rd_data | output | 8 | Low byte of the receive head word |
| rd_err | input | 1 | Processor reads the error register |
| wr_data | input | 1 | Processor writes the data port |
| wr_byte | input | 8 | Byte written |
| tx_hi | input | 3 | Upper bits of transmit words from control |
| tx_pop | input | 1 | Serializer takes the head transmit word |
| tx_word | output | 11 | Head transmit word |
| tx_word_valid | output | 1 | Transmit queue not empty |
| tx_busy | input | 1 | Transmitter is sending |
| loopback | input | 1 | Internal loopback enabled |
| tx_active | output | 1 | Transmit activity output, gated by loopback |
| irq_sel | input | 2 | Receiver interrupt source select |
| rx_irq | output | 1 | Receiver interrupt request |
| status | output | 8 | Status byte |

## Verification
The hardest state to reach is a receive queue that still holds words while data ready is low. It takes an error event that falls between pushes, so the bench pushes words, injects a fault, drains the queue while watching the flag stay low, and then pushes once more. An overflow is reached the same way: the bench fills the queue without popping and pushes a fifth word. It then pops all four words, which shows the dropped word never landed. The interrupt select is swept across all four codes for each of five flag states set up from reset.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
    localparam int HI_W   = 3;
    localparam int BYTE_W = 8;
    localparam int WORD_W = HI_W + BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } xfs_word_t;

    typedef enum logic [1:0] {
        IRQ_FULL_ERR = 2'b00,
        IRQ_DAV_ERR  = 2'b01,
        IRQ_NONE     = 2'b10,
        IRQ_ACTIVE   = 2'b11
    } irq_sel_e;

    typedef struct packed {
        logic            tx_full;
        logic            tx_act;
        logic            rx_err;
        logic            rx_act;
        logic            dav;
        logic [HI_W-1:0] head_hi;
    } xfs_status_t;

    typedef struct packed {
        logic err;
        logic act;
        logic dav;
    } rx_flags_t;

    function automatic logic irq_pick(irq_sel_e sel, rx_flags_t f, logic rx_full);
        logic r;
        case (sel)
            IRQ_FULL_ERR: r = rx_full | f.err;
            IRQ_DAV_ERR:  r = f.dav | f.err;
            IRQ_ACTIVE:   r = f.act;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xfs_word_fifo.sv
module xfs_word_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         one_left,
    output logic         pushed,
    output logic         popped,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic [W-1:0]  last_q;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign one_left = (count == CW'(1));
    assign popped   = pop & ~empty;
    assign pushed   = push & (~full | popped);
    assign ovf      = push & full & ~popped;
    assign dout     = empty ? last_q : mem[rptr];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
            last_q <= '0;
        end else begin
            if (pushed) begin
                mem[wptr] <= din;
                wptr      <= nxt(wptr);
            end
            if (popped) begin
                last_q <= mem[rptr];
                rptr   <= nxt(rptr);
            end
            if (pushed && !popped)
                count <= count + CW'(1);
            else if (popped && !pushed)
                count <= count - CW'(1);
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count) && $stable(wptr));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> $stable(rptr) && $stable(dout));
endmodule

// File: rtl/xfs_rx_flags.sv
module xfs_rx_flags
    import xfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xrst,
    input  logic      rx_start,
    input  logic      rx_eom,
    input  logic      rx_fault,
    input  logic      ovf,
    input  logic      pushed,
    input  logic      popped,
    input  logic      one_left,
    input  logic      rd_err,
    output rx_flags_t flags
);
    rx_flags_t f_q;
    logic      err_evt;

    assign err_evt = rx_fault | ovf;
    assign flags   = f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            if (err_evt)
                f_q.err <= 1'b1;
            else if (rd_err || xrst)
                f_q.err <= 1'b0;

            if (rx_eom || err_evt)
                f_q.act <= 1'b0;
            else if (rx_start)
                f_q.act <= 1'b1;

            if (err_evt)
                f_q.dav <= 1'b0;
            else if (pushed)
                f_q.dav <= 1'b1;
            else if (popped && one_left)
                f_q.dav <= 1'b0;
        end
    end

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_fault || ovf) |=> flags.err);
    // R5
    act_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_eom || rx_fault || ovf) |=> !flags.act);
    // R6
    dav_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_fault || ovf) |=> !flags.dav);
endmodule

// File: rtl/xcvr_fifo_status.sv
module xcvr_fifo_status
    import xfs_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 xrst,
    input  logic                 rx_push,
    input  logic [WORD_W-1:0]    rx_word,
    input  logic                 rx_start,
    input  logic                 rx_eom,
    input  logic                 rx_fault,
    input  logic                 rd_data_en,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic                 rd_err,
    input  logic                 wr_data,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic [HI_W-1:0]      tx_hi,
    input  logic                 tx_pop,
    output logic [WORD_W-1:0]    tx_word,
    output logic                 tx_word_valid,
    input  logic                 tx_busy,
    input  logic                 loopback,
    output logic                 tx_active,
    input  logic [1:0]           irq_sel,
    output logic                 rx_irq,
    output logic [7:0]           status
);
    xfs_word_t   rx_head, tx_in;
    logic        rx_full, rx_empty, rx_one, rx_pushed, rx_popped, rx_ovf;
    logic        tx_full, tx_empty, tx_one, tx_pushed, tx_popped, tx_ovf;
    rx_flags_t   flags;
    xfs_status_t st;

    assign tx_in = '{hi: tx_hi, lo: wr_byte};

    xfs_word_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_word),
        .pop(rd_data_en), .dout(rx_head),
        .full(rx_full), .empty(rx_empty), .one_left(rx_one),
        .pushed(rx_pushed), .popped(rx_popped), .ovf(rx_ovf)
    );

    xfs_word_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(wr_data), .din(tx_in),
        .pop(tx_pop), .dout(tx_word),
        .full(tx_full), .empty(tx_empty), .one_left(tx_one),
        .pushed(tx_pushed), .popped(tx_popped), .ovf(tx_ovf)
    );

    xfs_rx_flags u_flags (
        .clk(clk), .rst(rst), .xrst(xrst),
        .rx_start(rx_start), .rx_eom(rx_eom), .rx_fault(rx_fault),
        .ovf(rx_ovf), .pushed(rx_pushed), .popped(rx_popped),
        .one_left(rx_one), .rd_err(rd_err), .flags(flags)
    );

    assign tx_word_valid = ~tx_empty;
    assign tx_active     = tx_busy & ~loopback;
    assign rd_data       = rx_head.lo;
    assign rx_irq        = irq_pick(irq_sel_e'(irq_sel), flags, rx_full);

    always_comb begin
        st.tx_full = tx_full;
        st.tx_act  = tx_busy;
        st.rx_err  = flags.err;
        st.rx_act  = flags.act;
        st.dav     = flags.dav;
        st.head_hi = rx_head.hi;
    end
    assign status = st;

    // R10
    loop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        loopback |-> !tx_active);
    // R3
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && status[7] && !tx_pop) |=> status[7]);
endmodule

// File: tb/test_xcvr_fifo_status.sv
module test_xcvr_fifo_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1, xrst = 1'b0;
    logic        rx_push = 1'b0, rx_start = 1'b0, rx_eom = 1'b0, rx_fault = 1'b0;
    logic [10:0] rx_word = '0;
    logic        rd_data_en = 1'b0, rd_err = 1'b0, wr_data = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic [2:0]  tx_hi = '0;
    logic        tx_pop = 1'b0, tx_busy = 1'b0, loopback = 1'b0;
    logic [1:0]  irq_sel = 2'b00;
    logic [7:0]  rd_data, status;
    logic [10:0] tx_word;
    logic        tx_word_valid, tx_active, rx_irq;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xcvr_fifo_status i_xcvr_fifo_status (
        .clk(clk), .rst(rst), .xrst(xrst), .rx_push(rx_push), .rx_word(rx_word),
        .rx_start(rx_start), .rx_eom(rx_eom), .rx_fault(rx_fault),
        .rd_data_en(rd_data_en), .rd_data(rd_data), .rd_err(rd_err),
        .wr_data(wr_data), .wr_byte(wr_byte), .tx_hi(tx_hi), .tx_pop(tx_pop),
        .tx_word(tx_word), .tx_word_valid(tx_word_valid), .tx_busy(tx_busy),
        .loopback(loopback), .tx_active(tx_active), .irq_sel(irq_sel),
        .rx_irq(rx_irq), .status(status)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    task automatic rx_in(logic [10:0] w);
        rx_word = w; rx_push = 1'b1; step(); rx_push = 1'b0;
    endtask

    task automatic rx_read();
        rd_data_en = 1'b1; step(); rd_data_en = 1'b0;
    endtask

    function automatic logic [10:0] rxw(int k);
        return {3'(k + 5), 8'(8'h30 + k * 7)};
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 irq", rx_irq, 0);
        chk("R1 txvalid", tx_word_valid, 0);
        chk("R1 rddata", rd_data, 8'h00);

        // R10 busy/loopback sweep
        for (int b = 0; b < 4; b++) begin
            tx_busy = b[0]; loopback = b[1]; #1;
            chk("R10 status6", status[6], b[0]);
            chk("R10 txact", tx_active, b[0] & ~b[1]);
        end
        tx_busy = 0; loopback = 0;

        // R3 transmit fill, overfill, drain
        for (int k = 0; k < 5; k++) begin
            tx_hi = 3'(k); wr_byte = 8'(8'hA0 + k); wr_data = 1'b1; step(); wr_data = 1'b0;
            chk("R3 txfull", status[7], k >= 3);
            chk("R2 txfull bit7", status[7] ? 8'h80 : 8'h00, (k >= 3) ? 8'h80 : 8'h00);
        end
        for (int k = 0; k < 4; k++) begin
            chk("R3 txvalid", tx_word_valid, 1);
            chk("R3 txword", tx_word, {3'(k), 8'(8'hA0 + k)});
            tx_pop = 1'b1; step(); tx_pop = 1'b0;
            chk("R3 txfull after pop", status[7], 0);
        end
        chk("R3 txempty", tx_word_valid, 0);

        // R6 R8 receive fill and drain
        for (int k = 0; k < 3; k++) begin
            rx_in(rxw(k));
            chk("R6 dav set", status[3], 1);
        end
        for (int k = 0; k < 3; k++) begin
            chk("R8 rddata", rd_data, rxw(k) & 11'hFF);
            chk("R2 head hi", status[2:0], rxw(k) >> 8);
            rx_read();
            chk("R6 dav after pop", status[3], k < 2);
        end
        rx_read();
        chk("R8 empty read data", rd_data, rxw(2) & 11'hFF);
        chk("R8 empty read hi", status[2:0], rxw(2) >> 8);
        chk("R8 no error", status[5], 0);
        rx_in(rxw(9));
        chk("R8 after empty pop", rd_data, rxw(9) & 11'hFF);
        rx_read();

        // R7 overflow
        for (int k = 0; k < 5; k++) rx_in(rxw(10 + k));
        chk("R7 ovf err", status[5], 1);
        chk("R7 ovf dav", status[3], 0);
        for (int k = 0; k < 4; k++) begin
            chk("R7 kept word", rd_data, rxw(10 + k) & 11'hFF);
            rx_read();
        end
        rx_read();
        chk("R7 dropped word", rd_data, rxw(13) & 11'hFF);

        // R4 error flag
        rd_err = 1; step(); rd_err = 0;
        chk("R4 rd clear", status[5], 0);
        rx_fault = 1; step(); rx_fault = 0;
        chk("R4 fault set", status[5], 1);
        xrst = 1; step(); xrst = 0;
        chk("R4 xrst clear", status[5], 0);
        rx_fault = 1; rd_err = 1; step(); rx_fault = 0; rd_err = 0;
        chk("R4 set wins", status[5], 1);
        rd_err = 1; step(); rd_err = 0;

        // R5 receiver active
        rx_start = 1; step(); rx_start = 0;
        chk("R5 start", status[4], 1);
        rx_eom = 1; step(); rx_eom = 0;
        chk("R5 eom", status[4], 0);
        rx_start = 1; rx_eom = 1; step(); rx_start = 0; rx_eom = 0;
        chk("R5 clear wins", status[4], 0);
        rx_start = 1; step(); rx_start = 0;
        rx_fault = 1; step(); rx_fault = 0;
        chk("R5 err clear", status[4], 0);

        // R6 error with words queued
        do_reset();
        rx_in(rxw(20)); rx_in(rxw(21));
        chk("R6 dav two", status[3], 1);
        rx_fault = 1; step(); rx_fault = 0;
        chk("R6 err clears dav", status[3], 0);
        chk("R6 head kept", rd_data, rxw(20) & 11'hFF);
        rx_read();
        chk("R6 dav stays low", status[3], 0);
        chk("R6 second word", rd_data, rxw(21) & 11'hFF);
        rx_in(rxw(22));
        chk("R6 dav on new word", status[3], 1);

        // R9 interrupt select sweep over five flag states
        for (int s = 0; s < 5; s++) begin
            logic e_full, e_err, e_dav, e_act;
            do_reset();
            e_full = 0; e_err = 0; e_dav = 0; e_act = 0;
            case (s)
                1: begin rx_fault = 1; step(); rx_fault = 0; e_err = 1; end
                2: begin rx_in(rxw(1)); e_dav = 1; end
                3: begin rx_start = 1; step(); rx_start = 0; e_act = 1; end
                4: begin for (int k = 0; k < 4; k++) rx_in(rxw(k)); e_full = 1; e_dav = 1; end
                default: ;
            endcase
            for (int sel = 0; sel < 4; sel++) begin
                logic exp;
                irq_sel = 2'(sel); #1;
                case (sel)
                    0: exp = e_full | e_err;
                    1: exp = e_dav | e_err;
                    2: exp = 1'b0;
                    default: exp = e_act;
                endcase
                chk("R9 irq", rx_irq, exp);
            end
            irq_sel = 0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule